// File: doc/BRIEF.md
# Bus Activity Display Conditioner

This block turns the synchronised lines of a parallel asynchronous backplane into one indicator bit per line for a front-panel LED display. Every line is active low on the bus; after a two-flop synchroniser it is inverted, so an indicator bit of 1 always means the line is asserted.

The lines fall into three groups, and each group has its own presentation.
- **Cycle group:** data, address, address modifier, strobes, direction, width, acknowledge, error and the interrupt-acknowledge chain. These are frozen at the end of each transfer. The capture happens when the transfer acknowledge, the bus error or the block's own pseudo-acknowledge rises.
- **Grant-in lines:** these are frozen when bus-busy rises.
- **Stretched lines:** interrupt requests, bus requests, bus clear, bus-busy and the utility lines. These are lengthened so that a short pulse stays visible for a fixed number of milliseconds.

A raw mode bypasses capture and stretching, and shows every line live.

The block also contains a pseudo-acknowledge generator. When it is enabled, a transfer that no slave acknowledges within a window of one to four seconds is ended by the block, which drives the acknowledge itself. The block keeps a sticky flag recording that this has happened. A halt option freezes the whole display on the first bus error until the next reset. All time intervals are derived from a clock frequency parameter.

Top module: `bus_activity_display`

## Requirements
- R1: While reset is asserted and after reset with idle (high) inputs, every indicator bit, the acknowledge drive and the pseudo-acknowledge flag are 0.
- R2: In raw mode every indicator equals the inverted level of its bus line, within a fixed latency of four clock cycles. A line driven low shows as 1.
- R3: Outside raw mode, the cycle-group indicators show the lines sampled at the latest rising assertion of acknowledge, bus error or pseudo-acknowledge. The vector is ordered {error, acknowledge, address strobe, other lines}. A change of the lines between two such strobes does not change the indicators.
- R4: Outside raw mode, the grant-in indicators show the grant-in lines sampled when bus-busy became asserted. Later changes while bus-busy stays asserted have no effect.
- R5: Outside raw mode, a stretched line that is asserted for even one cycle keeps its indicator at 1 for at least STRETCH_MS milliseconds of clock cycles. The indicator clears after that. The stretched vector is ordered {bus-busy, other stretched lines}.
- R6: With pseudo-acknowledge enabled, if address strobe stays asserted with neither acknowledge nor bus error, the acknowledge drive asserts after the selected window. Timeout code 0 selects 4 s, 1 selects 3 s, 2 selects 2 s and 3 selects 1 s. The drive also acts as a cycle-group capture strobe.
- R7: An acknowledge or a bus error seen before the window expires cancels the timer for that transfer, and no acknowledge is driven.
- R8: Once asserted, the acknowledge drive stays asserted while address strobe is asserted. It releases when address strobe deasserts.
- R9: The pseudo-acknowledge flag sets when the drive asserts and stays set until reset.
- R10: With halt enabled, the display freezes on the first bus error, showing the cycle captured by that error, and stays frozen until reset. Raw-mode changes have no effect while it is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_ni | input | 1 | Bus address strobe, active low |
| dtack_ni | input | 1 | Bus transfer acknowledge, active low |
| berr_ni | input | 1 | Bus error, active low |
| bbsy_ni | input | 1 | Bus busy, active low |
| cyc_ni | input | CYC_W | Other cycle-group lines, active low |
| gnt_ni | input | GNT_W | Grant-in lines, active low |
| str_ni | input | STR_W | Stretched lines other than bus-busy, active low |
| raw_mode_i | input | 1 | 1 = live display of every line |
| ack_gen_en_i | input | 1 | Enable the pseudo-acknowledge generator |
| halt_en_i | input | 1 | Enable freezing of the display on a bus error |
| ack_tmo_i | input | 2 | Pseudo-acknowledge window code |
| led_cyc_o | output | CYC_W+3 | Cycle-group indicators {error, ack, strobe, lines} |
| led_gnt_o | output | GNT_W | Grant-in indicators |
| led_str_o | output | STR_W+1 | Stretched indicators {bus-busy, lines} |
| ack_drive_o | output | 1 | Pseudo-acknowledge drive, 1 = assert acknowledge |
| ack_seen_o | output | 1 | Sticky flag: pseudo-acknowledge has been generated |

## Verification
The hardest situation to reach is a timeout window expiring. It needs thousands of cycles of address strobe held with no answer, and it has to be paired with the cancelled case, where an answer arrives just inside the window. The bench sets the clock frequency parameter to 1 kHz, so one second is 1000 cycles. It then samples the acknowledge drive shortly before and shortly after each selected window, for three of the four codes. The halt freeze is reached by enabling halt, raising a bus error, and then switching to raw mode with new line values. If the freeze did not hold, those new values would show at once.

// File: rtl/bad_pkg.sv
package bad_pkg;
  localparam int unsigned MAX_TMO_S = 4;

  function automatic int unsigned ms_cycles(int unsigned clk_hz, int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction

  typedef enum logic [1:0] {
    TMO_4S = 2'd0,
    TMO_3S = 2'd1,
    TMO_2S = 2'd2,
    TMO_1S = 2'd3
  } tmo_e;
endpackage

// File: rtl/bad_sync.sv
module bad_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/bad_stretch.sv
module bad_stretch #(
  parameter int unsigned W     = 16,
  parameter int unsigned HOLD  = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] led_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (line_i[i])       cnt_q <= HOLD_C;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign led_o[i] = line_i[i] | (cnt_q != '0);

    // R5: an assertion stays visible on the following cycle
    a_r5_hold_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_i[i] |=> led_o[i]);
  end
endmodule

// File: rtl/bad_ack_timer.sv
module bad_ack_timer
  import bad_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] tmo_i,
  input  logic       as_i,
  input  logic       dtack_i,
  input  logic       berr_i,
  output logic       ack_o,
  output logic       seen_o
);
  localparam int unsigned CW = $clog2(MAX_TMO_S * CLK_HZ + 1);
  localparam logic [CW-1:0] LIM_4S = CW'(4 * CLK_HZ);
  localparam logic [CW-1:0] LIM_3S = CW'(3 * CLK_HZ);
  localparam logic [CW-1:0] LIM_2S = CW'(2 * CLK_HZ);
  localparam logic [CW-1:0] LIM_1S = CW'(1 * CLK_HZ);

  logic [CW-1:0] lim, cnt_q;
  logic          as_q, armed_q, ack_q, seen_q;

  always_comb begin
    unique case (tmo_e'(tmo_i))
      TMO_4S:  lim = LIM_4S;
      TMO_3S:  lim = LIM_3S;
      TMO_2S:  lim = LIM_2S;
      default: lim = LIM_1S;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q    <= 1'b0;
      armed_q <= 1'b0;
      ack_q   <= 1'b0;
      seen_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      as_q   <= as_i;
      seen_q <= seen_q | ack_q;
      if (!as_i) begin
        armed_q <= 1'b0;
        ack_q   <= 1'b0;
        cnt_q   <= '0;
      end else if (!as_q) begin
        // new transfer: timer starts at the strobe edge
        armed_q <= en_i;
        cnt_q   <= '0;
      end else if (armed_q && en_i) begin
        if (dtack_i || berr_i) begin
          armed_q <= 1'b0;
        end else if (cnt_q == lim - 1'b1) begin
          ack_q   <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ack_o  = ack_q;
  assign seen_o = seen_q;

  a_r6_ack_needs_open_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> ($past(as_i) && $past(en_i) && !$past(dtack_i)));
  a_r8_release_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && as_i) |=> (ack_q || !as_i));
  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> seen_q);
  a_r9_flag_follows_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> seen_q);
endmodule

// File: rtl/bus_activity_display.sv
module bus_activity_display
  import bad_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned STRETCH_MS = 15,
  parameter int unsigned CYC_W      = 75,
  parameter int unsigned GNT_W      = 8,
  parameter int unsigned STR_W      = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             as_ni,
  input  logic             dtack_ni,
  input  logic             berr_ni,
  input  logic             bbsy_ni,
  input  logic [CYC_W-1:0] cyc_ni,
  input  logic [GNT_W-1:0] gnt_ni,
  input  logic [STR_W-1:0] str_ni,
  input  logic             raw_mode_i,
  input  logic             ack_gen_en_i,
  input  logic             halt_en_i,
  input  logic [1:0]       ack_tmo_i,
  output logic [CYC_W+2:0] led_cyc_o,
  output logic [GNT_W-1:0] led_gnt_o,
  output logic [STR_W:0]   led_str_o,
  output logic             ack_drive_o,
  output logic             ack_seen_o
);
  localparam int unsigned ALL_W  = 4 + CYC_W + GNT_W + STR_W;
  localparam int unsigned HOLD   = ms_cycles(CLK_HZ, STRETCH_MS);
  localparam int unsigned CAP_W  = CYC_W + 3;
  localparam int unsigned SLED_W = STR_W + 1;

  logic [ALL_W-1:0] sync_s;
  logic             as_s, dtack_s, berr_s, bbsy_s;
  logic [CYC_W-1:0] cyc_s;
  logic [GNT_W-1:0] gnt_s;
  logic [STR_W-1:0] str_s;

  bad_sync #(.W(ALL_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (~{bbsy_ni, berr_ni, dtack_ni, as_ni, cyc_ni, gnt_ni, str_ni}),
    .q_o    (sync_s)
  );

  assign {bbsy_s, berr_s, dtack_s, as_s, cyc_s, gnt_s, str_s} = sync_s;

  logic ack_q;

  bad_ack_timer #(.CLK_HZ(CLK_HZ)) u_ack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ack_gen_en_i),
    .tmo_i   (ack_tmo_i),
    .as_i    (as_s),
    .dtack_i (dtack_s),
    .berr_i  (berr_s),
    .ack_o   (ack_q),
    .seen_o  (ack_seen_o)
  );

  logic [SLED_W-1:0] str_led;

  bad_stretch #(.W(SLED_W), .HOLD(HOLD)) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({bbsy_s, str_s}),
    .led_o  (str_led)
  );

  // capture strobes
  logic cyc_strobe, cyc_strobe_q, bbsy_q, berr_q;
  logic cyc_rise, bbsy_rise, berr_rise;

  assign cyc_strobe = dtack_s | berr_s | ack_q;
  assign cyc_rise   = cyc_strobe & ~cyc_strobe_q;
  assign bbsy_rise  = bbsy_s & ~bbsy_q;
  assign berr_rise  = berr_s & ~berr_q;

  logic [CAP_W-1:0] live_cyc, cap_cyc_q;
  logic [GNT_W-1:0] cap_gnt_q;

  assign live_cyc = {berr_s, dtack_s, as_s, cyc_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_strobe_q <= 1'b0;
      bbsy_q       <= 1'b0;
      berr_q       <= 1'b0;
      cap_cyc_q    <= '0;
      cap_gnt_q    <= '0;
    end else begin
      cyc_strobe_q <= cyc_strobe;
      bbsy_q       <= bbsy_s;
      berr_q       <= berr_s;
      if (cyc_rise)  cap_cyc_q <= live_cyc;
      if (bbsy_rise) cap_gnt_q <= gnt_s;
    end
  end

  // halt: freeze one cycle after the error capture so it is shown
  logic halt_pend_q, halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_pend_q <= 1'b0;
      halted_q    <= 1'b0;
    end else begin
      if (halt_en_i && berr_rise) halt_pend_q <= 1'b1;
      if (halt_pend_q)            halted_q    <= 1'b1;
    end
  end

  logic [CAP_W-1:0]  view_cyc, led_cyc_q;
  logic [GNT_W-1:0]  view_gnt, led_gnt_q;
  logic [SLED_W-1:0] view_str, led_str_q;

  always_comb begin
    if (raw_mode_i) begin
      view_cyc = live_cyc;
      view_gnt = gnt_s;
      view_str = {bbsy_s, str_s};
    end else begin
      view_cyc = cap_cyc_q;
      view_gnt = cap_gnt_q;
      view_str = str_led;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_cyc_q <= '0;
      led_gnt_q <= '0;
      led_str_q <= '0;
    end else if (!halted_q) begin
      led_cyc_q <= view_cyc;
      led_gnt_q <= view_gnt;
      led_str_q <= view_str;
    end
  end

  assign led_cyc_o   = led_cyc_q;
  assign led_gnt_o   = led_gnt_q;
  assign led_str_o   = led_str_q;
  assign ack_drive_o = ack_q;

  a_r10_display_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> ($stable(led_cyc_q) && $stable(led_gnt_q) && $stable(led_str_q)));
  a_r10_freeze_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> halted_q);
  a_r10_freeze_needs_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_pend_q) |-> ($past(berr_s) && $past(halt_en_i)));
  a_r3_capture_by_strobe_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw_mode_i && !halted_q && !cyc_rise && $past(!raw_mode_i)) |=> $stable(led_cyc_q) || $past(cyc_rise, 2));
endmodule

// File: tb/tb_bus_activity_display.sv
module tb_bus_activity_display;
  localparam int unsigned CLK_HZ = 1000;
  localparam int unsigned CYC_W  = 75;
  localparam int unsigned GNT_W  = 8;
  localparam int unsigned STR_W  = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, dtack_n = 1'b1, berr_n = 1'b1, bbsy_n = 1'b1;
  logic [CYC_W-1:0] cyc_n = '1;
  logic [GNT_W-1:0] gnt_n = '1;
  logic [STR_W-1:0] str_n = '1;
  logic raw = 1'b0, ack_en = 1'b0, halt_en = 1'b0;
  logic [1:0] tmo = 2'd3;

  logic [CYC_W+2:0] led_cyc;
  logic [GNT_W-1:0] led_gnt;
  logic [STR_W:0]   led_str;
  logic             ack_drv, ack_seen;

  always #5 clk = ~clk;

  bus_activity_display #(
    .CLK_HZ(CLK_HZ), .STRETCH_MS(15), .CYC_W(CYC_W), .GNT_W(GNT_W), .STR_W(STR_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .as_ni(as_n), .dtack_ni(dtack_n), .berr_ni(berr_n),
    .bbsy_ni(bbsy_n), .cyc_ni(cyc_n), .gnt_ni(gnt_n), .str_ni(str_n),
    .raw_mode_i(raw), .ack_gen_en_i(ack_en), .halt_en_i(halt_en), .ack_tmo_i(tmo),
    .led_cyc_o(led_cyc), .led_gnt_o(led_gnt), .led_str_o(led_str),
    .ack_drive_o(ack_drv), .ack_seen_o(ack_seen)
  );

  typedef struct {
    string        req;
    int           sel;
    logic [127:0] exp;
  } item_t;

  item_t q[$];
  int pushed = 0, popped = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam int S_CYC = 0, S_GNT = 1, S_STR = 2, S_ACK = 3, S_SEEN = 4;

  function automatic logic [127:0] observe(int sel);
    case (sel)
      S_CYC:   return 128'(led_cyc);
      S_GNT:   return 128'(led_gnt);
      S_STR:   return 128'(led_str);
      S_ACK:   return 128'(ack_drv);
      default: return 128'(ack_seen);
    endcase
  endfunction

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [127:0] act;
        it  = q.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
        popped++;
      end
    end
  end

  task automatic expect_val(string req, int sel, logic [127:0] e);
    item_t it;
    it.req = req; it.sel = sel; it.exp = e;
    q.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  function automatic logic [127:0] cyc_exp(logic e, logic a, logic s, logic [CYC_W-1:0] p);
    return 128'({e, a, s, p});
  endfunction

  localparam logic [CYC_W-1:0] PA = 75'h1_2345_6789_ABCD_EF01;
  localparam logic [CYC_W-1:0] PB = 75'h6_F0F0_0F0F_5555_AAAA;
  localparam logic [CYC_W-1:0] PC = 75'h0_0000_DEAD_BEEF_0001;
  localparam logic [CYC_W-1:0] PD = 75'h7_FFFF_0000_FFFF_0000;
  localparam logic [CYC_W-1:0] PE = 75'h2_4680_1357_9BDF_ACE0;
  localparam logic [CYC_W-1:0] PF = 75'h5_A5A5_A5A5_A5A5_A5A5;
  localparam logic [CYC_W-1:0] PH = 75'h3_1111_2222_3333_4444;
  localparam logic [CYC_W-1:0] PJ = 75'h4_9999_8888_7777_6666;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    step(2);
    // R1: during reset
    expect_val("R1 cyc in reset", S_CYC, '0);
    rst_n = 1'b1;
    step(4);
    expect_val("R1 cyc", S_CYC, '0);
    expect_val("R1 gnt", S_GNT, '0);
    expect_val("R1 str", S_STR, '0);
    expect_val("R1 ack", S_ACK, '0);
    expect_val("R1 seen", S_SEEN, '0);

    // R2: raw mode, two patterns
    raw = 1'b1;
    cyc_n = ~PA;
    step(5);
    expect_val("R2 raw pattern A", S_CYC, cyc_exp(0, 0, 0, PA));
    cyc_n = ~PB; as_n = 1'b0; gnt_n = ~8'h3C;
    step(5);
    expect_val("R2 raw pattern B", S_CYC, cyc_exp(0, 0, 1, PB));
    expect_val("R2 raw grant", S_GNT, 128'(8'h3C));
    as_n = 1'b1; gnt_n = '1;

    // R3: capture on acknowledge
    raw = 1'b0;
    cyc_n = ~PC; as_n = 1'b0;
    step(6);
    expect_val("R3 no strobe yet", S_CYC, '0);
    dtack_n = 1'b0;
    step(6);
    expect_val("R3 captured on ack", S_CYC, cyc_exp(0, 1, 1, PC));
    cyc_n = ~PD;
    step(6);
    expect_val("R3 change between strobes ignored", S_CYC, cyc_exp(0, 1, 1, PC));
    dtack_n = 1'b1; as_n = 1'b1;
    step(6);
    expect_val("R3 held after release", S_CYC, cyc_exp(0, 1, 1, PC));
    cyc_n = ~PE; as_n = 1'b0;
    step(4);
    berr_n = 1'b0;
    step(6);
    expect_val("R3 captured on error", S_CYC, cyc_exp(1, 0, 1, PE));
    berr_n = 1'b1; as_n = 1'b1; cyc_n = '1;
    step(4);

    // R4: grant capture on bus-busy
    gnt_n = ~8'hA1;
    step(4);
    bbsy_n = 1'b0;
    step(6);
    expect_val("R4 grant captured", S_GNT, 128'(8'hA1));
    gnt_n = ~8'h5E;
    step(6);
    expect_val("R4 later grant ignored", S_GNT, 128'(8'hA1));
    expect_val("R5 busy shown while held", S_STR, 128'(16'h8000));
    bbsy_n = 1'b1; gnt_n = '1;
    step(40);
    expect_val("R5 busy stretch expired", S_STR, '0);

    // R5: one-cycle pulse stretched
    str_n[3] = 1'b0;
    step(1);
    str_n[3] = 1'b1;
    step(12);
    expect_val("R5 pulse still shown", S_STR, 128'(16'h0008));
    step(20);
    expect_val("R5 pulse cleared", S_STR, '0);

    // R6: 1 s window, code 3
    ack_en = 1'b1; tmo = 2'd3;
    cyc_n = ~PF; as_n = 1'b0;
    step(990);
    expect_val("R6 code3 before window", S_ACK, '0);
    step(20);
    expect_val("R6 code3 after window", S_ACK, 128'(1));
    expect_val("R9 flag set", S_SEEN, 128'(1));
    expect_val("R6 pseudo ack captures", S_CYC, cyc_exp(0, 0, 1, PF));
    step(50);
    expect_val("R8 held while strobe", S_ACK, 128'(1));
    as_n = 1'b1;
    step(5);
    expect_val("R8 released", S_ACK, '0);
    expect_val("R9 flag sticky", S_SEEN, 128'(1));

    // R6: 4 s window, code 0
    tmo = 2'd0;
    as_n = 1'b0;
    step(3950);
    expect_val("R6 code0 before window", S_ACK, '0);
    step(60);
    expect_val("R6 code0 after window", S_ACK, 128'(1));
    as_n = 1'b1;
    step(5);

    // R6: 2 s window, code 2
    tmo = 2'd2;
    as_n = 1'b0;
    step(1950);
    expect_val("R6 code2 before window", S_ACK, '0);
    step(60);
    expect_val("R6 code2 after window", S_ACK, 128'(1));
    as_n = 1'b1;
    step(5);

    // R7: real acknowledge cancels
    tmo = 2'd3;
    as_n = 1'b0;
    step(100);
    dtack_n = 1'b0;
    step(1500);
    expect_val("R7 cancelled by ack", S_ACK, '0);
    dtack_n = 1'b1; as_n = 1'b1;
    step(5);
    ack_en = 1'b0;

    // R10: halt freeze
    halt_en = 1'b1;
    cyc_n = ~PH; as_n = 1'b0;
    step(4);
    berr_n = 1'b0;
    step(8);
    expect_val("R10 error cycle shown", S_CYC, cyc_exp(1, 0, 1, PH));
    berr_n = 1'b1; as_n = 1'b1;
    cyc_n = ~PJ; raw = 1'b1;
    step(10);
    expect_val("R10 frozen against raw", S_CYC, cyc_exp(1, 0, 1, PH));
    do_reset();
    step(4);
    expect_val("R10 reset lifts freeze", S_CYC, cyc_exp(0, 0, 0, PJ));
    expect_val("R1 flag cleared by reset", S_SEEN, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule